// File: doc/BRIEF.md
# Timed Power Mode Controller

This block steps a processor core between three power modes: full-speed run, an idle mode where the core clock is gated but logic keeps its supply, and a sleep mode where the main supply is switched off and only an always-on domain stays alive. A mode change starts when software raises a request pulse with a destination code, or when a wake event arrives from the always-on domain. The controller then drives the core clock enable, an isolation enable and the main-supply enable in a fixed order. It holds each phase for a latency counted in clock cycles, and reports the new mode only once that latency has run out.

Each transition has its own latency. Going between run and idle is short and the same in both directions. Entering sleep runs through three equal timed steps: stop the clock, clamp the outputs, then cut the supply. Coming out of sleep is by far the slowest path. The mode code output lets an external energy accumulator weight time spent in each mode; the nominal weights are 400 mW for run, 50 mW for idle and 0.16 mW for sleep.

Top module: `pmc_top`

## Requirements
- R1: After reset, mode is run (2'b00), busy is 0, cpu_clk_en is 1, main_pwr_en is 1 and iso_en is 0.
- R2: Run to idle and idle to run each hold busy for LAT_DOZE cycles. cpu_clk_en is 0 from the first busy cycle of run to idle, and it returns to 1 only when idle to run completes.
- R3: Entering sleep from run or from idle takes three steps of LAT_STEP cycles each. In step one only the clock is stopped, in step two iso_en is 1 as well, and in step three main_pwr_en is 0 as well.
- R4: Sleep to run raises main_pwr_en in the first busy cycle. iso_en stays 1 and cpu_clk_en stays 0 for LAT_WAKE cycles, after which the core is in plain run.
- R5: busy is 1 starting the cycle after an accepted request. It stays 1 for exactly the latency of that transition. mode keeps the source code while busy is 1 and changes to the destination code in the cycle busy falls.
- R6: A request or wake event that arrives while busy is 1 has no effect.
- R7: A request is ignored if its code equals the current mode, if its code is 2'b11, or if it asks for idle while in sleep. Sleep may only exit to run.
- R8: A wake pulse in idle or sleep starts a transition to run and takes precedence over a request in the same cycle. A wake pulse in run is ignored.
- R9: Mode codes are run 2'b00, idle 2'b01, sleep 2'b10. The code 2'b11 is never output.
- R10: cpu_clk_en is 1 only in stable run. main_pwr_en is 0 only in the third sleep-entry step and in stable sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle software mode request strobe |
| req_mode | input | 2 | Requested destination mode code |
| wake | input | 1 | Wake event, asks for a return to run |
| cpu_clk_en | output | 1 | Core clock gate enable |
| main_pwr_en | output | 1 | Main supply switch enable |
| iso_en | output | 1 | Output isolation clamp enable |
| mode | output | 2 | Current stable mode code |
| busy | output | 1 | Transition in progress |

## Verification
The bench builds the block with LAT_DOZE=10, LAT_STEP=30 and LAT_WAKE=1600. With these values every path, including the long wake from sleep, completes in a few thousand cycles. The values also keep each sleep-entry step long enough to hit it with requests and wake pulses in its middle. Phase boundaries, stray stimulus during transitions and illegal request codes are compared cycle by cycle against a behavioural timeline model.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_IDLE  = 2'b01,
    MODE_SLEEP = 2'b10
  } pmc_mode_e;

  typedef enum logic [3:0] {
    ST_RUN,
    ST_IDLE,
    ST_SLEEP,
    ST_R2I,
    ST_I2R,
    ST_SLP1,
    ST_SLP2,
    ST_SLP3,
    ST_WAKE
  } pmc_state_e;

  function automatic int unsigned pmc_max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/pmc_req_arb.sv
module pmc_req_arb
  import pmc_pkg::*;
(
  input  logic      req_valid,
  input  logic [1:0] req_mode,
  input  logic      wake,
  input  pmc_mode_e cur_mode,
  input  logic      busy,
  output logic      start,
  output pmc_mode_e target
);
  logic code_ok;
  logic path_ok;
  logic req_ok;
  logic wake_ok;

  always_comb begin
    code_ok = (req_mode != 2'b11) && (req_mode != 2'(cur_mode));
    path_ok = (cur_mode != MODE_SLEEP) || (req_mode == 2'(MODE_RUN));
    req_ok  = req_valid && code_ok && path_ok;
    wake_ok = wake && (cur_mode != MODE_RUN);
    start   = !busy && (wake_ok || req_ok);
    if (wake_ok) begin
      target = MODE_RUN;
    end else if (req_ok) begin
      target = pmc_mode_e'(req_mode);
    end else begin
      target = cur_mode;
    end
  end
endmodule

// File: rtl/pmc_step_timer.sv
module pmc_step_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
#(
  parameter int LAT_DOZE = 10,
  parameter int LAT_STEP = 30,
  parameter int LAT_WAKE = 1600,
  parameter int CNT_W    = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  pmc_mode_e        target,
  input  logic             done,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output pmc_mode_e        cur_mode,
  output logic             busy,
  output logic             cpu_clk_en,
  output logic             main_pwr_en,
  output logic             iso_en
);
  localparam logic [CNT_W-1:0] LV_DOZE = CNT_W'(LAT_DOZE - 1);
  localparam logic [CNT_W-1:0] LV_STEP = CNT_W'(LAT_STEP - 1);
  localparam logic [CNT_W-1:0] LV_WAKE = CNT_W'(LAT_WAKE - 1);

  pmc_state_e state, nxt_state;
  pmc_mode_e  nxt_mode;

  always_comb begin
    nxt_state = state;
    nxt_mode  = cur_mode;
    load      = 1'b0;
    load_val  = '0;
    case (state)
      ST_RUN, ST_IDLE, ST_SLEEP: begin
        if (start) begin
          load = 1'b1;
          case (target)
            MODE_RUN: begin
              if (state == ST_SLEEP) begin
                nxt_state = ST_WAKE;
                load_val  = LV_WAKE;
              end else begin
                nxt_state = ST_I2R;
                load_val  = LV_DOZE;
              end
            end
            MODE_IDLE: begin
              nxt_state = ST_R2I;
              load_val  = LV_DOZE;
            end
            MODE_SLEEP: begin
              nxt_state = ST_SLP1;
              load_val  = LV_STEP;
            end
            default: load = 1'b0;
          endcase
        end
      end
      ST_R2I: if (done) begin
        nxt_state = ST_IDLE;
        nxt_mode  = MODE_IDLE;
      end
      ST_I2R, ST_WAKE: if (done) begin
        nxt_state = ST_RUN;
        nxt_mode  = MODE_RUN;
      end
      ST_SLP1: if (done) begin
        nxt_state = ST_SLP2;
        load      = 1'b1;
        load_val  = LV_STEP;
      end
      ST_SLP2: if (done) begin
        nxt_state = ST_SLP3;
        load      = 1'b1;
        load_val  = LV_STEP;
      end
      ST_SLP3: if (done) begin
        nxt_state = ST_SLEEP;
        nxt_mode  = MODE_SLEEP;
      end
      default: begin
        nxt_state = ST_RUN;
        nxt_mode  = MODE_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      cur_mode <= MODE_RUN;
    end else begin
      state    <= nxt_state;
      cur_mode <= nxt_mode;
    end
  end

  always_comb begin
    busy        = !(state inside {ST_RUN, ST_IDLE, ST_SLEEP});
    cpu_clk_en  = (state == ST_RUN);
    main_pwr_en = !(state inside {ST_SLP3, ST_SLEEP});
    iso_en      = state inside {ST_SLP2, ST_SLP3, ST_SLEEP, ST_WAKE};
  end
endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
#(
  parameter int LAT_DOZE = 10,
  parameter int LAT_STEP = 30,
  parameter int LAT_WAKE = 1600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  input  logic       wake,
  output logic       cpu_clk_en,
  output logic       main_pwr_en,
  output logic       iso_en,
  output logic [1:0] mode,
  output logic       busy
);
  localparam int unsigned LAT_MAX = pmc_max3(LAT_DOZE, LAT_STEP, LAT_WAKE);
  localparam int CNT_W = $clog2(LAT_MAX + 1);

  pmc_mode_e        cur_mode;
  pmc_mode_e        target;
  logic             start;
  logic             load;
  logic             done;
  logic [CNT_W-1:0] load_val;

  pmc_req_arb u_arb (
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .wake      (wake),
    .cur_mode  (cur_mode),
    .busy      (busy),
    .start     (start),
    .target    (target)
  );

  pmc_step_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .done     (done)
  );

  pmc_seq #(
    .LAT_DOZE (LAT_DOZE),
    .LAT_STEP (LAT_STEP),
    .LAT_WAKE (LAT_WAKE),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .target      (target),
    .done        (done),
    .load        (load),
    .load_val    (load_val),
    .cur_mode    (cur_mode),
    .busy        (busy),
    .cpu_clk_en  (cpu_clk_en),
    .main_pwr_en (main_pwr_en),
    .iso_en      (iso_en)
  );

  assign mode = cur_mode;
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_mode,
  input logic       wake,
  input logic       cpu_clk_en,
  input logic       main_pwr_en,
  input logic       iso_en,
  input logic [1:0] mode,
  input logic       busy
);
  // R10
  clk_only_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> (!busy && mode == 2'b00));

  // R2
  run_has_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mode == 2'b00) |-> cpu_clk_en);

  // R3
  pwr_off_clamped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !main_pwr_en |-> (iso_en && !cpu_clk_en));

  // R4
  pwr_on_from_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_pwr_en) |-> (busy && iso_en && mode == 2'b10));

  // R5
  mode_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode));

  // R5
  mode_moves_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (mode != $past(mode)));

  // R9
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

  // R10
  sleep_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mode == 2'b10) |-> !main_pwr_en);
endmodule

bind pmc_top pmc_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_mode    (req_mode),
  .wake        (wake),
  .cpu_clk_en  (cpu_clk_en),
  .main_pwr_en (main_pwr_en),
  .iso_en      (iso_en),
  .mode        (mode),
  .busy        (busy)
);

// File: tb/pmc_top_tb_top.sv
module pmc_top_tb_top;
  localparam int CLK_PER = 10;
  localparam int T_DOZE = 10;
  localparam int T_STEP = 30;
  localparam int T_WAKE = 1600;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_mode = 2'b00;
  logic       wake = 1'b0;
  logic       cpu_clk_en, main_pwr_en, iso_en, busy;
  logic [1:0] mode;

  int n_chk = 0;
  int n_fail = 0;
  bit done_run = 1'b0;

  // behavioural model state
  int m_mode = 0;
  int m_src = 0;
  int m_tgt = 0;
  bit m_busy = 1'b0;
  int m_t = 0;
  int m_len = 0;

  always #(CLK_PER/2) clk = ~clk;

  pmc_top #(.LAT_DOZE(T_DOZE), .LAT_STEP(T_STEP), .LAT_WAKE(T_WAKE)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .wake(wake), .cpu_clk_en(cpu_clk_en), .main_pwr_en(main_pwr_en),
    .iso_en(iso_en), .mode(mode), .busy(busy)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  function automatic int lat_of(input int src, input int tgt);
    if (tgt == 2) return 3 * T_STEP;
    if (src == 2) return T_WAKE;
    return T_DOZE;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_busy = 0; m_t = 0;
    end else if (m_busy) begin
      if (m_t == m_len) begin
        m_busy = 0;
        m_mode = m_tgt;
      end else begin
        m_t++;
      end
    end else begin
      int want;
      bit go;
      go = 0;
      want = m_mode;
      if (wake && m_mode != 0) begin
        go = 1; want = 0;
      end else if (req_valid && req_mode != 2'b11 && int'(req_mode) != m_mode &&
                   !(m_mode == 2 && req_mode != 2'b00)) begin
        go = 1; want = int'(req_mode);
      end
      if (go) begin
        m_src = m_mode; m_tgt = want; m_busy = 1; m_t = 1;
        m_len = lat_of(m_src, m_tgt);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      int e_pwr, e_iso, e_clk;
      e_clk = (!m_busy && m_mode == 0) ? 1 : 0;
      e_pwr = 1;
      e_iso = 0;
      if (m_busy && m_tgt == 2) begin
        if (m_t > T_STEP) e_iso = 1;
        if (m_t > 2 * T_STEP) e_pwr = 0;
      end else if (m_busy && m_src == 2) begin
        e_iso = 1;
      end else if (!m_busy && m_mode == 2) begin
        e_iso = 1; e_pwr = 0;
      end
      check("R5 busy", int'(busy), int'(m_busy));
      check("R9 mode", int'(mode), m_mode);
      check("R2 cpu_clk_en", int'(cpu_clk_en), e_clk);
      check("R3 iso_en", int'(iso_en), e_iso);
      check("R10 main_pwr_en", int'(main_pwr_en), e_pwr);
    end
  end

  task automatic pulse(input bit r, input logic [1:0] code, input bit w);
    @(negedge clk);
    req_valid = r; req_mode = code; wake = w;
    @(negedge clk);
    req_valid = 1'b0; wake = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle_cycles(3);
    // R1 reset values
    check("R1 mode", int'(mode), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 cpu_clk_en", int'(cpu_clk_en), 1);
    check("R1 main_pwr_en", int'(main_pwr_en), 1);
    check("R1 iso_en", int'(iso_en), 0);
    rst_n = 1'b1;
    idle_cycles(2);

    // R8 wake in run ignored
    pulse(0, 2'b00, 1);
    check("R8 wake in run", int'(busy), 0);
    // R7 same-mode and 2'b11 ignored
    pulse(1, 2'b00, 0);
    check("R7 same mode", int'(busy), 0);
    pulse(1, 2'b11, 0);
    check("R7 code 11", int'(busy), 0);

    // R2 run to idle, with stray request mid-way (R6)
    pulse(1, 2'b01, 0);
    check("R2 busy after accept", int'(busy), 1);
    idle_cycles(3);
    pulse(1, 2'b10, 0);
    idle_cycles(T_DOZE);
    check("R6 mid-transition request ignored", int'(mode), 1);
    check("R6 not busy after", int'(busy), 0);

    // R2 idle to run
    pulse(1, 2'b00, 0);
    idle_cycles(T_DOZE + 2);
    check("R2 back in run", int'(mode), 0);

    // R3 run to sleep with wake and request mid-step (R6)
    pulse(1, 2'b10, 0);
    idle_cycles(T_STEP + 5);
    pulse(0, 2'b00, 1);
    pulse(1, 2'b01, 0);
    idle_cycles(2 * T_STEP);
    check("R3 in sleep", int'(mode), 2);
    check("R6 wake during entry ignored", int'(busy), 0);

    // R7 sleep to idle illegal
    pulse(1, 2'b01, 0);
    check("R7 sleep to idle", int'(busy), 0);
    idle_cycles(2);
    check("R7 still sleep", int'(mode), 2);

    // R8 / R4 wake from sleep, with request competing
    pulse(1, 2'b00, 1);
    check("R4 power on at once", int'(main_pwr_en), 1);
    idle_cycles(T_WAKE);
    check("R4 run after wake", int'(mode), 0);

    // R3 idle to sleep then R4 request run from sleep
    pulse(1, 2'b01, 0);
    idle_cycles(T_DOZE + 1);
    pulse(1, 2'b10, 0);
    idle_cycles(3 * T_STEP + 1);
    check("R3 idle to sleep", int'(mode), 2);
    pulse(1, 2'b00, 0);
    idle_cycles(T_WAKE + 1);
    check("R4 request to run", int'(mode), 0);

    // R8 wake beats request in idle
    pulse(1, 2'b01, 0);
    idle_cycles(T_DOZE + 1);
    pulse(1, 2'b10, 1);
    idle_cycles(T_DOZE + 1);
    check("R8 wake wins", int'(mode), 0);
    check("R8 clock back", int'(cpu_clk_en), 1);

    done_run = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_run) begin
      done_run = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule